// File: doc/BRIEF.md
# Outbound Address Window Translator

This block maps addresses taken from an outbound aperture on the local memory bus onto 64-bit PCIe bus addresses. The aperture is cut into a table of equally sized windows. One global field sets the size of every window, as a power of two in megabytes. Each window owns a pair of 32-bit offset registers. The low register carries the window's own enable in bit 0 and the lower part of the translated base in its upper bits. The high register carries the upper 32 bits of the translated base. A single enable bit in a command register gates the whole table.

Software programs the table through a simple register port. Writes take effect at the clock edge. A read returns its data one cycle later. On the request side, an address offset within the aperture is presented with a valid strobe. One cycle later the block answers with a valid strobe, a hit flag and the translated address. The address is zero on a miss.

Top module: `ob_xlat_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `rsp_valid`, `rsp_hit` and `reg_rdata` are zero. After reset, every register reads back as zero.
- R2: A register read issued in one cycle returns the stored value on `reg_rdata` in the next cycle, and `reg_rdata` is zero in any cycle that does not follow a read. The command register sits at byte offset 0x004 and returns all 32 bits last written. The size register sits at 0x030 and returns the 3-bit size in bits 2:0, with zeros above. Window n has its low register at 0x200 + 8n and its high register at 0x204 + 8n, each returning the 32 bits last written.
- R3: The window used for a request is the request address shifted right by 20 plus the size field. With size s, each window spans 2^s MB.
- R4: On a hit, `rsp_addr` equals {high register, low register with bit 0 cleared} plus the request address bits below bit 20+s, added over the full 64 bits.
- R5: When bit 1 of the command register is clear, every request misses, whatever the other bits of that register hold.
- R6: A request whose window has bit 0 of its low register clear misses.
- R7: A request whose window index is 32 or more misses. Every miss returns `rsp_addr` equal to zero.
- R8: `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high, and `rsp_hit` is high only together with `rsp_valid`.
- R9: When a register write and a request fall in the same cycle, the request is translated with the settings held before that write. The write is visible to the next request.
- R10: A read of an address that maps to no register returns zero. A write to such an address, including a misaligned one inside the window range, changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd_en` |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Address offset within the outbound aperture |
| rsp_valid | output | 1 | Translation response strobe |
| rsp_hit | output | 1 | Response hit flag |
| rsp_addr | output | 64 | Translated address, zero on a miss |

## Verification
A table write and a translation request can land on the same clock edge. They interact only when the write targets the window, the size field or the enable bit that the request depends on. The bench drives a write and a request in one cycle for each of these cases: the window's base is rewritten, the window is disabled, and the global enable is turned on. It then checks that the response matches a model updated only after the request has been scored. A second request afterwards confirms that the new setting took hold.

// File: rtl/ob_xlat_pkg.sv
package ob_xlat_pkg;

    localparam int DW       = 32;
    localparam int RA_W     = 12;
    localparam int SZ_W     = 3;
    localparam int MB_SHIFT = 20;
    localparam int EN_BIT   = 1;
    localparam int XA_W     = 64;

    localparam logic [RA_W-1:0] CMD_OFS  = 12'h004;
    localparam logic [RA_W-1:0] SIZE_OFS = 12'h030;
    localparam logic [RA_W-1:0] WIN_OFS  = 12'h200;

    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
    } win_t;

    typedef struct packed {
        logic            valid;
        logic            hit;
        logic [XA_W-1:0] addr;
    } rsp_t;

    function automatic logic [XA_W-1:0] win_base(input win_t w);
        return {w.hi, w.lo[DW-1:1], 1'b0};
    endfunction

endpackage

// File: rtl/ob_xlat_regs.sv
module ob_xlat_regs
    import ob_xlat_pkg::*;
#(
    parameter int NUM_WIN = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [RA_W-1:0]        addr,
    input  logic [DW-1:0]          wdata,
    output logic [DW-1:0]          rdata,
    output logic                   xlat_en,
    output logic [SZ_W-1:0]        win_sz,
    output win_t [NUM_WIN-1:0]     wins
);

    logic [DW-1:0]      cmd_q;
    logic [SZ_W-1:0]    sz_q;
    logic               cmd_sel;
    logic               sz_sel;
    logic [NUM_WIN-1:0] lo_sel;
    logic [NUM_WIN-1:0] hi_sel;
    logic [DW-1:0]      rd_mux;

    assign cmd_sel = (addr == CMD_OFS);
    assign sz_sel  = (addr == SIZE_OFS);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            sz_q  <= '0;
        end else if (wr_en) begin
            if (cmd_sel) cmd_q <= wdata;
            if (sz_sel)  sz_q  <= wdata[SZ_W-1:0];
        end
    end

    // one offset register pair per window
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        localparam logic [RA_W-1:0] LO_A = WIN_OFS + RA_W'(8 * g);
        localparam logic [RA_W-1:0] HI_A = LO_A + RA_W'(4);
        logic [DW-1:0] lo_q;
        logic [DW-1:0] hi_q;

        assign lo_sel[g] = (addr == LO_A);
        assign hi_sel[g] = (addr == HI_A);

        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (wr_en) begin
                if (lo_sel[g]) lo_q <= wdata;
                if (hi_sel[g]) hi_q <= wdata;
            end
        end

        assign wins[g].lo = lo_q;
        assign wins[g].hi = hi_q;
    end

    always_comb begin
        rd_mux = '0;
        if (cmd_sel) rd_mux = cmd_q;
        if (sz_sel)  rd_mux = DW'(sz_q);
        for (int i = 0; i < NUM_WIN; i++) begin
            if (lo_sel[i]) rd_mux = wins[i].lo;
            if (hi_sel[i]) rd_mux = wins[i].hi;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_en ? rd_mux : '0;
    end

    assign xlat_en = cmd_q[EN_BIT];
    assign win_sz  = sz_q;

endmodule

// File: rtl/ob_xlat_lookup.sv
module ob_xlat_lookup
    import ob_xlat_pkg::*;
#(
    parameter int NUM_WIN = 32,
    parameter int IN_AW   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [IN_AW-1:0]   req_addr,
    input  logic               xlat_en,
    input  logic [SZ_W-1:0]    win_sz,
    input  win_t [NUM_WIN-1:0] wins,
    output rsp_t               rsp
);

    localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    logic [7:0]       shift;
    logic [IN_AW-1:0] idx_full;
    logic [IDX_W-1:0] idx;
    logic             in_range;
    logic [IN_AW-1:0] off_mask;
    logic [IN_AW-1:0] off;
    win_t             sel;
    logic             hit;
    logic [XA_W-1:0]  xaddr;

    assign shift    = 8'(MB_SHIFT) + 8'(win_sz);
    assign idx_full = req_addr >> shift;
    assign in_range = (idx_full < IN_AW'(NUM_WIN));
    assign idx      = idx_full[IDX_W-1:0];
    assign sel      = in_range ? wins[idx] : '0;
    assign off_mask = ~({IN_AW{1'b1}} << shift);
    assign off      = req_addr & off_mask;
    assign hit      = xlat_en && in_range && sel.lo[0];
    assign xaddr    = win_base(sel) + {{(XA_W-IN_AW){1'b0}}, off};

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp <= '0;
        end else begin
            rsp.valid <= req_valid;
            rsp.hit   <= req_valid && hit;
            rsp.addr  <= (req_valid && hit) ? xaddr : '0;
        end
    end

endmodule

// File: rtl/ob_xlat_top.sv
module ob_xlat_top
    import ob_xlat_pkg::*;
#(
    parameter int NUM_WIN = 32,
    parameter int IN_AW   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              req_valid,
    input  logic [IN_AW-1:0]  req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [XA_W-1:0]   rsp_addr
);

    logic               xlat_en;
    logic [SZ_W-1:0]    win_sz;
    win_t [NUM_WIN-1:0] wins;
    rsp_t               rsp;

    ob_xlat_regs #(.NUM_WIN(NUM_WIN)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .rd_en   (reg_rd_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .xlat_en (xlat_en),
        .win_sz  (win_sz),
        .wins    (wins)
    );

    ob_xlat_lookup #(.NUM_WIN(NUM_WIN), .IN_AW(IN_AW)) lookup_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .xlat_en   (xlat_en),
        .win_sz    (win_sz),
        .wins      (wins),
        .rsp       (rsp)
    );

    assign rsp_valid = rsp.valid;
    assign rsp_hit   = rsp.hit;
    assign rsp_addr  = rsp.addr;

endmodule

// File: rtl/ob_xlat_chk.sv
module ob_xlat_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_rd_en,
    input logic [31:0] reg_rdata,
    input logic        req_valid,
    input logic        xlat_en,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic [63:0] rsp_addr
);

    assert_rsp_follows_req_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_hit_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);

    assert_miss_addr_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_addr == 64'd0));

    assert_gate_off_miss_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !xlat_en) |=> !rsp_hit);

    assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !reg_rd_en |=> (reg_rdata == 32'd0));

endmodule

bind ob_xlat_top ob_xlat_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_rd_en (reg_rd_en),
    .reg_rdata (reg_rdata),
    .req_valid (req_valid),
    .xlat_en   (xlat_en),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_addr  (rsp_addr)
);

// File: tb/ob_xlat_top_tb_top.sv
module ob_xlat_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [63:0] rsp_addr;

    int tests = 0;
    int fails = 0;

    logic [31:0] m_lo [32];
    logic [31:0] m_hi [32];
    logic [31:0] m_cmd;
    logic [2:0]  m_sz;

    always #5 clk = ~clk;

    ob_xlat_top dut_i (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
        if (a == 12'h004) m_cmd = d;
        else if (a == 12'h030) m_sz = d[2:0];
        else if (a >= 12'h200 && a < 12'h300 && a[1:0] == 2'b00) begin
            if (a[2]) m_hi[(a - 12'h200) >> 3] = d;
            else      m_lo[(a - 12'h200) >> 3] = d;
        end
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        if (a == 12'h004) return m_cmd;
        if (a == 12'h030) return {29'd0, m_sz};
        if (a >= 12'h200 && a < 12'h300 && a[1:0] == 2'b00)
            return a[2] ? m_hi[(a - 12'h200) >> 3] : m_lo[(a - 12'h200) >> 3];
        return 32'd0;
    endfunction

    // returns {hit, address}
    function automatic logic [64:0] model_xlat(input logic [31:0] a);
        int          sh;
        logic [31:0] idx;
        logic [31:0] off;
        logic [63:0] base;
        sh  = 20 + int'(m_sz);
        idx = a >> sh;
        if (!m_cmd[1] || idx >= 32 || !m_lo[idx][0]) return 65'd0;
        off  = a & ((32'h1 << sh) - 32'h1);
        base = {m_hi[idx], m_lo[idx][31:1], 1'b0};
        return {1'b1, base + {32'd0, off}};
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        logic [31:0] exp;
        exp = model_read(a);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        check(tag, {32'd0, reg_rdata}, {32'd0, exp});
    endtask

    task automatic xl(input logic [31:0] a, input string tag);
        logic [64:0] exp;
        exp = model_xlat(a);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, {63'd0, rsp_valid}, 64'd1);
        check({tag, " hit"}, {63'd0, rsp_hit}, {63'd0, exp[64]});
        check({tag, " addr"}, rsp_addr, exp[63:0]);
    endtask

    // write and request in the same cycle: response must use pre-write state
    task automatic wr_and_xl(input logic [11:0] wa, input logic [31:0] wd,
                             input logic [31:0] a, input string tag);
        logic [64:0] exp;
        exp = model_xlat(a);
        reg_wr_en = 1'b1; reg_addr = wa; reg_wdata = wd;
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        reg_wr_en = 1'b0; req_valid = 1'b0;
        model_write(wa, wd);
        check({tag, " hit"}, {63'd0, rsp_hit}, {63'd0, exp[64]});
        check({tag, " addr"}, rsp_addr, exp[63:0]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] a;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
        m_cmd = '0; m_sz = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
        check("R1 rdata in reset", {32'd0, reg_rdata}, 64'd0);
        rst = 1'b0;
        check("R1 rsp_hit after reset", {63'd0, rsp_hit}, 64'd0);
        rd(12'h004, "R1 cmd after reset");
        rd(12'h030, "R1 size after reset");
        rd(12'h2F8, "R1 window31 lo after reset");

        // R2: readback
        wr(12'h004, 32'hA5A5_0003);
        rd(12'h004, "R2 cmd readback");
        wr(12'h030, 32'hFFFF_FFFE);
        rd(12'h030, "R2 size readback");
        wr(12'h21C, 32'h1234_5678);
        rd(12'h21C, "R2 window3 hi readback");
        @(negedge clk);
        check("R2 rdata idle", {32'd0, reg_rdata}, 64'd0);

        // R10: unmapped and misaligned accesses
        wr(12'h100, 32'hDEAD_BEEF);
        rd(12'h100, "R10 unmapped read");
        rd(12'h300, "R10 past window range");
        wr(12'h200, 32'h4000_0001);
        wr(12'h202, 32'hFFFF_FFFF);
        rd(12'h200, "R10 misaligned write ignored");

        // R3/R4: size 0, window 5
        wr(12'h030, 32'd0);
        wr(12'h004, 32'h0000_0002);
        wr(12'h228, 32'h8010_0001);
        wr(12'h22C, 32'h0000_00AB);
        xl(32'h0051_2345, "R3 R4 size0 win5");
        // R3: size 2 (4 MB windows), 0x0140_0000 -> window 5
        wr(12'h030, 32'd2);
        xl(32'h0170_0010, "R3 size2 win5");
        // R7: beyond window 31 at size 0
        wr(12'h030, 32'd0);
        xl(32'h0200_0000, "R7 beyond table");
        // R3/R7: largest size reaches window 31 at top of aperture
        wr(12'h030, 32'd7);
        wr(12'h2F8, 32'hFFF0_0001);
        wr(12'h2FC, 32'hFFFF_FFFF);
        xl(32'hFFFF_FFFF, "R3 R4 size7 win31 carry");
        // R6: disabled window
        wr(12'h030, 32'd0);
        xl(32'h0061_0000, "R6 disabled window");
        // R5: global enable clear, other bits set
        wr(12'h004, 32'hFFFF_FFFD);
        xl(32'h0051_2345, "R5 global off");

        // R9: same-cycle write and request
        wr_and_xl(12'h004, 32'h0000_0002, 32'h0051_0000, "R9 enable with request");
        xl(32'h0051_0000, "R9 enable visible after");
        wr_and_xl(12'h228, 32'h9000_0001, 32'h0050_0010, "R9 base rewrite");
        xl(32'h0050_0010, "R9 new base visible");
        wr_and_xl(12'h228, 32'h9000_0000, 32'h0050_0020, "R9 disable with request");
        xl(32'h0050_0020, "R9 disable visible");
        wr_and_xl(12'h030, 32'd1, 32'h0050_0030, "R9 size change");
        xl(32'h00A0_0030, "R9 new size visible");

        // random configurations and requests
        for (int round = 0; round < 6; round++) begin
            for (int w = 0; w < 32; w++) begin
                wr(12'(12'h200 + 8 * w), $urandom);
                wr(12'(12'h204 + 8 * w), $urandom);
            end
            wr(12'h030, {29'd0, 3'($urandom)});
            wr(12'h004, (round == 5) ? 32'h0 : ($urandom | 32'h2));
            for (int k = 0; k < 8; k++)
                rd(12'(12'h200 + 4 * ($urandom % 64)), "R2 random readback");
            for (int k = 0; k < 120; k++) begin
                a = $urandom;
                if ($urandom % 4 != 0)
                    a = a & ((32'h1 << (25 + int'(m_sz))) - 32'h1);
                xl(a, "R4 R6 R7 random request");
            end
        end

        @(negedge clk);
        check("R8 no response without request", {63'd0, rsp_valid}, 64'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule